// File: doc/BRIEF.md
# Compressed Branch Trace Encoder

This block takes the branch source addresses a processor core reports, one 32-bit address per accepted branch, and sends each one out as a short packet on a 4-bit trace data port with a sync strobe. Each packet carries only the low-order part of the address that differs from the last address actually sent: 4, 8, 16 or the full 32 bits. A host that has followed the stream rebuilds the full addresses from these packets. Between the core and the serializer sits a small packet queue. When that queue is full, a mode input picks the response: the new branch is dropped and the core keeps running, or the core is stalled until a slot frees up.

Every packet that goes out on the port is also written, as a size code plus the masked payload, into an on-chip capture store. A second mode input sets what the store does when it is full. It can overwrite its oldest record, or it can refuse new records. The trace port keeps running in both cases. The store is read out through a show-ahead pop port.

Top module: `trc_branch_encoder`

## Requirements
- R1: The size code is 0 when bits 31:4 of the new address equal those of the reference address, otherwise 1 when bits 31:8 equal, otherwise 2 when bits 31:16 equal, and otherwise 3. Codes 0, 1, 2 and 3 carry 4, 8, 16 and 32 payload bits.
- R2: The reference address is zero after reset. It takes the value of a branch only when that branch is accepted into the queue. A dropped or stalled branch leaves it unchanged.
- R3: The nibbles after the header carry the low bits of the address, least significant nibble first, one per clock. There are exactly 1, 2, 4 or 8 of them for codes 0 to 3, and trc_sync is low on each one.
- R4: Each packet begins with one header nibble on which trc_sync is high. Bits 1:0 of that nibble hold the size code and bits 3:2 are zero.
- R5: With realtime_mode high, core_stall never rises. A branch that arrives while the queue holds QDEPTH packets is discarded and never appears on the trace port.
- R6: With realtime_mode low, core_stall equals br_valid AND (queue holds QDEPTH packets). A branch held through the stall is accepted once a slot frees, so no branch is lost.
- R7: The queue accepts a branch in any cycle in which it holds fewer than QDEPTH packets. A packet accepted at one clock edge has its header driven after the next edge when the serializer is idle.
- R8: With wrap_mode high, a record written into a full capture store evicts the oldest record, so the store holds the latest CDEPTH packets in order.
- R9: With wrap_mode low, a full capture store ignores new records and keeps the first CDEPTH packets. Trace output continues unaffected.
- R10: After reset, trc_sync, trc_data, core_stall and cap_valid are all zero.
- R11: Packets go out back to back. The header of a queued packet follows the last payload nibble of the previous one with no idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch address valid this cycle |
| br_addr | input | 32 | Branch source address |
| realtime_mode | input | 1 | 1: drop branches when the queue is full; 0: stall the core |
| wrap_mode | input | 1 | 1: capture store overwrites its oldest record; 0: stops when full |
| cap_pop | input | 1 | Remove the oldest capture record |
| core_stall | output | 1 | Stall request to the core |
| trc_data | output | 4 | Trace data nibble |
| trc_sync | output | 1 | Marks the header nibble of a packet |
| cap_valid | output | 1 | Capture store holds at least one record |
| cap_code | output | 2 | Size code of the oldest capture record |
| cap_payload | output | 32 | Masked payload of the oldest capture record |

## Verification
The bench targets address pairs that differ only just inside and just outside each boundary at bit 4, 8 and 16. A wrong comparison width sends too few nibbles and the host reconstructs a corrupted address. In realtime mode it drives dense bursts that cause drops, and checks that the next packet is coded against the last address sent and not the dropped one. A design that updates the reference on a drop produces short packets the host cannot decode. In stall mode it holds branches through the stall and counts them at the end, which catches a design that lets a stalled branch slip through or lose its slot. It fills the capture store past capacity in both policies and checks that the oldest records are evicted or the newest refused, as the policy requires. It also checks header timing on every clock, which exposes an idle gap between packets or a header slipped into the middle of a payload.

// File: rtl/trc_pkg.sv
package trc_pkg;

  parameter int ADDR_W = 32;
  parameter int NIB_W  = 4;

  typedef enum logic [1:0] {
    SZ4  = 2'd0,
    SZ8  = 2'd1,
    SZ16 = 2'd2,
    SZ32 = 2'd3
  } sz_code_e;

  typedef struct packed {
    sz_code_e            code;
    logic [ADDR_W-1:0]   addr;
  } trc_rec_t;

  // number of payload nibbles for a size code
  function automatic logic [3:0] nib_count(input sz_code_e c);
    logic [3:0] n;
    unique case (c)
      SZ4:     n = 4'd1;
      SZ8:     n = 4'd2;
      SZ16:    n = 4'd4;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

  // payload mask for a size code
  function automatic logic [ADDR_W-1:0] pay_mask(input sz_code_e c);
    logic [ADDR_W-1:0] m;
    unique case (c)
      SZ4:     m = ADDR_W'(32'h0000_000F);
      SZ8:     m = ADDR_W'(32'h0000_00FF);
      SZ16:    m = ADDR_W'(32'h0000_FFFF);
      default: m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/trc_delta_enc.sv
module trc_delta_enc
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  output sz_code_e          code
);

  logic [ADDR_W-1:0] prev_q;
  logic [ADDR_W-1:0] prev_d;

  // widest shared upper field picks the shortest packet
  always_comb begin
    if (addr[ADDR_W-1:4] == prev_q[ADDR_W-1:4])
      code = SZ4;
    else if (addr[ADDR_W-1:8] == prev_q[ADDR_W-1:8])
      code = SZ8;
    else if (addr[ADDR_W-1:16] == prev_q[ADDR_W-1:16])
      code = SZ16;
    else
      code = SZ32;
  end

  always_comb begin
    prev_d = prev_q;
    if (accept) prev_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // R2: reference only moves on an accepted branch
  assert_ref_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> prev_q == $past(prev_q));

endmodule

// File: rtl/trc_pkt_queue.sv
module trc_pkt_queue
  import trc_pkg::*;
#(
  parameter int DEPTH = 2
)(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  trc_rec_t push_rec,
  input  logic     pop,
  output trc_rec_t head_rec,
  output logic     empty,
  output logic     full
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  trc_rec_t        mem [DEPTH];
  logic [IW-1:0]   wr_q, wr_d;
  logic [IW-1:0]   rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head_rec = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = wr_q + 1'b1;
    if (do_pop)  rd_d = rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_rec;
  end

  // R7: occupancy never exceeds the queue depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/trc_nibble_ser.sv
module trc_nibble_ser
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_avail,
  input  trc_rec_t         rec,
  output logic             take,
  output logic [NIB_W-1:0] trc_data,
  output logic             trc_sync
);

  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [3:0]        left_q, left_d;
  logic [NIB_W-1:0]  data_d;
  logic              sync_d;

  // a new packet may start on the cycle after the last payload nibble
  assign take = rec_avail && (left_q == 4'd0);

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    data_d = '0;
    sync_d = 1'b0;
    if (take) begin
      data_d = {2'b00, rec.code};
      sync_d = 1'b1;
      sh_d   = rec.addr;
      left_d = nib_count(rec.code);
    end else if (left_q != 4'd0) begin
      data_d = sh_q[NIB_W-1:0];
      sh_d   = sh_q >> NIB_W;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      left_q   <= '0;
      trc_data <= '0;
      trc_sync <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      left_q   <= left_d;
      trc_data <= data_d;
      trc_sync <= sync_d;
    end
  end

  // R4: header nibble keeps its upper bits clear
  assert_hdr_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trc_sync |-> trc_data[3:2] == 2'b00);

  // R3: every header is followed by at least one payload nibble
  assert_payload_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trc_sync |=> !trc_sync);

endmodule

// File: rtl/trc_capture_store.sv
module trc_capture_store
  import trc_pkg::*;
#(
  parameter int DEPTH = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_mode,
  input  logic              wr,
  input  sz_code_e          wr_code,
  input  logic [ADDR_W-1:0] wr_payload,
  input  logic              pop,
  output logic              valid,
  output sz_code_e          rd_code,
  output logic [ADDR_W-1:0] rd_payload
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  trc_rec_t        mem [DEPTH];
  logic [IW-1:0]   wr_q, wr_d;
  logic [IW-1:0]   rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            full, pop_ok, wr_ok, evict;

  assign full   = (cnt_q == CW'(DEPTH));
  assign pop_ok = pop && (cnt_q != '0);
  assign wr_ok  = wr && (!full || pop_ok || wrap_mode);
  assign evict  = wr && full && !pop_ok && wrap_mode;

  assign valid      = (cnt_q != '0);
  assign rd_code    = mem[rd_q].code;
  assign rd_payload = mem[rd_q].addr;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (wr_ok)           wr_d = wr_q + 1'b1;
    if (pop_ok || evict) rd_d = rd_q + 1'b1;
    if (wr_ok && !evict && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !(wr_ok && !evict)) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_q] <= '{code: wr_code, addr: wr_payload};
  end

  // R9: a full store in stop policy holds its contents
  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_mode && full && !pop) |=> (cnt_q == CW'(DEPTH)) && (rd_q == $past(rd_q)));

  // R8: a write into a full wrapping store evicts exactly the oldest record
  assert_wrap_evict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_mode && full && wr && !pop) |=> (cnt_q == CW'(DEPTH)) && (rd_q == $past(rd_q) + 1'b1));

  assert_cap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/trc_branch_encoder.sv
module trc_branch_encoder
  import trc_pkg::*;
#(
  parameter int QDEPTH = 2,
  parameter int CDEPTH = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        br_valid,
  input  logic [31:0] br_addr,
  input  logic        realtime_mode,
  input  logic        wrap_mode,
  input  logic        cap_pop,
  output logic        core_stall,
  output logic [3:0]  trc_data,
  output logic        trc_sync,
  output logic        cap_valid,
  output logic [1:0]  cap_code,
  output logic [31:0] cap_payload
);

  sz_code_e  enc_code;
  sz_code_e  st_code;
  trc_rec_t  q_in, q_head;
  logic      q_empty, q_full, accept, take;

  assign accept     = br_valid && !q_full;
  assign core_stall = br_valid && q_full && !realtime_mode;
  assign q_in       = '{code: enc_code, addr: br_addr};
  assign cap_code   = st_code;

  trc_delta_enc u_delta (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .addr   (br_addr),
    .code   (enc_code)
  );

  trc_pkt_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_rec (q_in),
    .pop      (take),
    .head_rec (q_head),
    .empty    (q_empty),
    .full     (q_full)
  );

  trc_nibble_ser u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_avail (!q_empty),
    .rec       (q_head),
    .take      (take),
    .trc_data  (trc_data),
    .trc_sync  (trc_sync)
  );

  trc_capture_store #(.DEPTH(CDEPTH)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap_mode  (wrap_mode),
    .wr         (take),
    .wr_code    (q_head.code),
    .wr_payload (q_head.addr & pay_mask(q_head.code)),
    .pop        (cap_pop),
    .valid      (cap_valid),
    .rd_code    (st_code),
    .rd_payload (cap_payload)
  );

  // R5: realtime policy never holds the core
  assert_rt_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    realtime_mode |-> !core_stall);

  // R6: a stall is only requested for a branch that is present
  assert_stall_needs_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> br_valid && !realtime_mode);

endmodule

// File: tb/tb_trc_branch_encoder.sv
module tb_trc_branch_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int QD = 2;
  localparam int CD = 8;
  localparam int MAXR = 8192;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid;
  logic [31:0] br_addr;
  logic        realtime_mode;
  logic        wrap_mode;
  logic        cap_pop;
  logic        core_stall;
  logic [3:0]  trc_data;
  logic        trc_sync;
  logic        cap_valid;
  logic [1:0]  cap_code;
  logic [31:0] cap_payload;

  trc_branch_encoder #(.QDEPTH(QD), .CDEPTH(CD)) dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_addr(br_addr),
    .realtime_mode(realtime_mode), .wrap_mode(wrap_mode), .cap_pop(cap_pop),
    .core_stall(core_stall), .trc_data(trc_data), .trc_sync(trc_sync),
    .cap_valid(cap_valid), .cap_code(cap_code), .cap_payload(cap_payload)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // expected packet list
  logic [1:0]  ec [MAXR];
  logic [31:0] ep [MAXR];
  int ne, mq, mh, ps;
  // cycle model
  int mcount, mrem;
  logic [31:0] mprev;
  logic msync;
  // monitor
  int mon_left, mon_idx;
  logic [31:0] mon_val;
  int drops, issued, acc_cnt;
  int unsigned seed_dummy;

  function automatic logic [1:0] f_code(input logic [31:0] p, input logic [31:0] a);
    if (p[31:4] == a[31:4])        return 2'd0;
    else if (p[31:8] == a[31:8])   return 2'd1;
    else if (p[31:16] == a[31:16]) return 2'd2;
    else                           return 2'd3;
  endfunction

  function automatic int f_nibs(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 8;
  endfunction

  function automatic logic [31:0] f_mask(input logic [1:0] c);
    return (c == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (4 * f_nibs(c))) - 32'h1);
  endfunction

  function automatic logic [31:0] f_next(input logic [31:0] b);
    int r;
    r = $urandom % 6;
    case (r)
      0: return b ^ ($urandom & 32'h0000_000F);
      1: return b ^ ($urandom & 32'h0000_00FF);
      2: return b ^ ($urandom & 32'h0000_FFFF);
      3: return $urandom;
      4: return b ^ 32'h0000_0010;
      default: return b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    ps = ne; mq = ne; mh = ne;
    mcount = 0; mrem = 0; mprev = '0; msync = 1'b0;
    mon_left = 0; mon_idx = 0; mon_val = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; br_valid = 1'b0; br_addr = '0; cap_pop = 1'b0;
    repeat (3) @(posedge clk);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic monitor();
    check(trc_sync === msync, "R11 sync timing", 64'(trc_sync), 64'(msync));
    if (trc_sync) begin
      check(mon_left == 0, "R3 header inside payload", 64'(mon_left), 64'd0);
      check(trc_data[3:2] == 2'b00, "R4 header upper bits", 64'(trc_data), 64'(trc_data[1:0]));
      if (mh < ne) begin
        check(trc_data[1:0] == ec[mh], "R1 size code", 64'(trc_data[1:0]), 64'(ec[mh]));
      end else begin
        check(1'b0, "R5 unexpected packet", 64'(trc_data), 64'd0);
      end
      mon_left = f_nibs(trc_data[1:0]);
      mon_idx = 0;
      mon_val = '0;
    end else if (mon_left > 0) begin
      mon_val = mon_val | (32'(trc_data) << (4 * mon_idx));
      mon_idx++;
      mon_left--;
      if (mon_left == 0) begin
        // R3 payload order and R2 reference choice both show here
        check(mon_val == ep[mh], "R3 payload", 64'(mon_val), 64'(ep[mh]));
        mh++;
      end
    end else begin
      check(trc_data == 4'd0, "R10 idle data", 64'(trc_data), 64'd0);
    end
  endtask

  task automatic tick(input logic v, input logic [31:0] a, output logic acc);
    logic pop;
    logic [1:0] c;
    @(negedge clk);
    monitor();
    br_valid = v;
    br_addr = a;
    #1;
    check(core_stall === (v && mcount == QD && !realtime_mode), "R6 stall",
          64'(core_stall), 64'(v && mcount == QD && !realtime_mode));
    if (realtime_mode) check(core_stall == 1'b0, "R5 no stall", 64'(core_stall), 64'd0);
    pop = (mcount > 0) && (mrem == 0);
    acc = v && (mcount < QD);
    if (pop) begin
      mrem = f_nibs(ec[mq]);
      mq++;
    end else if (mrem > 0) begin
      mrem--;
    end
    msync = pop;
    mcount = mcount + (acc ? 1 : 0) - (pop ? 1 : 0);
    if (acc) begin
      c = f_code(mprev, a);
      ec[ne] = c;
      ep[ne] = a & f_mask(c);
      ne++;
      mprev = a;
      acc_cnt++;
    end else if (v && realtime_mode) begin
      drops++;
    end
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int i = 0; i < n; i++) tick(1'b0, 32'h0, acc);
  endtask

  // stall-mode issue: hold the branch until accepted
  task automatic issue_hold(input logic [31:0] a);
    logic acc;
    issued++;
    acc = 1'b0;
    while (!acc) tick(1'b1, a, acc);
  endtask

  task automatic drain_cap(input bit wrap, input string req);
    int n, first;
    n = ne - ps;
    first = (wrap && n > CD) ? (ne - CD) : ps;
    if (n > CD) n = CD;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(cap_valid == 1'b1, req, 64'(cap_valid), 64'd1);
      check(cap_code == ec[first + i], req, 64'(cap_code), 64'(ec[first + i]));
      check(cap_payload == ep[first + i], req, 64'(cap_payload), 64'(ep[first + i]));
      cap_pop = 1'b1;
      @(posedge clk);
      #1 cap_pop = 1'b0;
    end
    @(negedge clk);
    check(cap_valid == 1'b0, req, 64'(cap_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic acc;
    logic [31:0] a;
    seed_dummy = $urandom(32'h0000_5EED);
    ne = 0; drops = 0; issued = 0; acc_cnt = 0;
    realtime_mode = 1'b0;
    wrap_mode = 1'b1;
    do_reset();

    // R10 reset state
    @(negedge clk);
    check(trc_sync == 1'b0, "R10 sync", 64'(trc_sync), 64'd0);
    check(trc_data == 4'd0, "R10 data", 64'(trc_data), 64'd0);
    check(core_stall == 1'b0, "R10 stall", 64'(core_stall), 64'd0);
    check(cap_valid == 1'b0, "R10 cap_valid", 64'(cap_valid), 64'd0);

    // directed code boundaries (R1, R2: first address coded against zero)
    issue_hold(32'h0000_0003);
    idle(4);
    issue_hold(32'h1234_5678);
    idle(12);
    issue_hold(32'h1234_567F);
    idle(4);
    issue_hold(32'h1234_5688);
    idle(6);
    issue_hold(32'h1234_A688);
    idle(8);
    issue_hold(32'h1234_A688);
    idle(4);
    issue_hold(32'h1235_0000);
    idle(12);
    // back-to-back burst forcing stalls (R6, R7, R11)
    issue_hold(32'hFFFF_0000);
    issue_hold(32'hFFFF_0001);
    issue_hold(32'hFFFF_0101);
    issue_hold(32'h0000_0101);
    issue_hold(32'h0000_0102);
    idle(30);

    // random stall mode with wrap capture
    a = 32'h8000_0000;
    for (int i = 0; i < 250; i++) begin
      if ($urandom % 3 != 0) begin
        a = f_next(a);
        issue_hold(a);
      end else begin
        tick(1'b0, 32'h0, acc);
      end
    end
    idle(30);
    check(issued == acc_cnt, "R6 no lost branch", 64'(acc_cnt), 64'(issued));
    check(mh == ne, "R6 all packets seen", 64'(mh), 64'(ne));
    drain_cap(1'b1, "R8 wrap capture");

    // realtime mode with stop capture
    realtime_mode = 1'b1;
    wrap_mode = 1'b0;
    do_reset();
    a = 32'h4000_1000;
    for (int i = 0; i < 800; i++) begin
      if ($urandom % 4 != 0) begin
        a = f_next(a);
        tick(1'b1, a, acc);
      end else begin
        tick(1'b0, 32'h0, acc);
      end
    end
    idle(30);
    check(drops > 0, "R5 drops occurred", 64'(drops), 64'd1);
    check(mh == ne, "R9 trace continues", 64'(mh), 64'(ne));
    drain_cap(1'b0, "R9 stop capture");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule